// File: doc/BRIEF.md
# Neural Crossbar Matching Scheduler

This block picks which input-to-output pairs of an N-by-N input-queued crossbar may transfer in the next switch cycle. Each crosspoint has a single-bit threshold neuron. A neuron is held down by the active neurons that share its row (same input) or its column (same output). It is pushed up by a common bias and by a priority bonus that is scaled per request. When a start strobe arrives, the requested neurons turn on together. The grid then updates all neurons in lockstep, one iteration per clock. It stops when an iteration changes nothing or when an iteration limit is reached.

Mutual inhibition alone can leave conflicts behind. This happens, for example, when two equally favoured neurons hold each other at a zero sum. The surviving neurons therefore pass through a combinational legalizer. The legalizer resolves each row and then each column by priority. It then adds every request that still has a free input and a free output. The grant matrix, a one-cycle done pulse and the number of iterations used are returned together. The weights, bias and requests are sampled at the start strobe, so the caller may change them during a run.

Top module: `xbar_neuro_sched`

## Requirements
- R1: After reset, `busy` and `done` are 0, `grant` is all zero and `iters` is 0.
- R2: A `start` sampled while idle latches `req`, `prio`, `wt_row`, `wt_col`, `wt_prio` and `bias`, and raises `busy` on the next cycle. Each neuron's initial state equals its request bit. Crosspoint (input i, output j) is bit i*N+j of `req` and `grant`, and its priority is field `prio[(i*N+j)*PW +: PW]` (unsigned; larger means more urgent).
- R3: In each iteration, every neuron computes sum = bias + wt_prio*prio - wt_row*(other active neurons in its row) - wt_col*(other active neurons in its column), at full precision. An unrequested neuron stays off. An off neuron turns on when sum > 0. An on neuron stays on when sum >= 0.
- R4: The run ends at the first iteration whose next state equals the current state, or at iteration MAX_IT (default 2N), whichever comes first. `iters` reports the number of iterations evaluated. `done` is high in the cycle after the `iters`-th clock edge that follows the edge at which `start` was sampled.
- R5: `done` is high for exactly one cycle, and `busy` is low in that cycle. `grant` and `iters` stay unchanged until the next `done`.
- R6: Every grant has at most one bit set per input row and per output column, and `grant` is a subset of the latched requests.
- R7: Conflicts among the final neurons are resolved first within each row and then within each column. The neuron kept is the one with the highest priority. On a tie within a row the lowest output index wins, and on a tie within a column the lowest input index wins.
- R8: The grant is maximal. After conflict resolution, every remaining request whose input and output are both free is added in ascending bit order. As a consequence, the grant count is at least half the size of a maximum matching.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the running result nor the phase after `done`.
- R10: With wt_row = wt_col = bias = 2 and no priority, suppose input 1 requests outputs 1 and 3 and input 3 requests output 1. Then the grant is {1→3, 3→1} after 2 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scheduling run (ignored while busy) |
| req | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| prio | input | N*N*PW | Per-crosspoint priority fields |
| wt_row | input | WW | Row inhibition weight (unsigned) |
| wt_col | input | WW | Column inhibition weight (unsigned) |
| wt_prio | input | WW | Priority bonus weight (unsigned) |
| bias | input | WW | Common bias (signed) |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result strobe |
| grant | output | N*N | Legal grant matrix |
| iters | output | clog2(MAX_IT+1) | Iterations used by the last run |

## Verification
The properties assume that the request matrix compared against `grant` is the one present when `start` is accepted in the idle phase. This is why the checker keeps its own copy of that matrix. They also assume that no second run is begun before the first result has been seen. The stimulus changes requests only at falling clock edges. It drives starts only while the block is idle, except in one deliberate case that checks a start arriving mid-run is ignored. The weights are held fixed across each run, so every table entry's iteration count follows from a hand-evaluated sequence of sums.

// File: rtl/xbar_sched_pkg.sv
// Shared types for the neural crossbar scheduler.
package xbar_sched_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/xbar_cell.sv
// One crosspoint neuron: computes its inhibited sum from the current row and
// column states and decides its next single-bit state.
// Assumes row_v and col_v include this neuron's own state bit.
module xbar_cell #(
    parameter int N  = 4,
    parameter int PW = 2,
    parameter int WW = 6
) (
    input  logic                 req_b,
    input  logic                 on_b,
    input  logic [N-1:0]         row_v,
    input  logic [N-1:0]         col_v,
    input  logic [PW-1:0]        prio_b,
    input  logic [WW-1:0]        wt_row,
    input  logic [WW-1:0]        wt_col,
    input  logic [WW-1:0]        wt_prio,
    input  logic signed [WW-1:0] bias,
    output logic                 nxt_b
);
    localparam int CW = $clog2(N + 1);
    localparam int SW = WW + PW + CW + 3;

    logic [CW-1:0]        row_cnt, col_cnt;
    logic [WW+PW-1:0]     p_prod;
    logic [WW+CW-1:0]     r_prod, c_prod;
    logic signed [SW-1:0] sum;

    // Count active competitors, form weighted terms and apply the threshold.
    always_comb begin
        row_cnt = CW'($countones(row_v)) - {{(CW-1){1'b0}}, on_b};
        col_cnt = CW'($countones(col_v)) - {{(CW-1){1'b0}}, on_b};
        p_prod  = wt_prio * prio_b;
        r_prod  = wt_row * row_cnt;
        c_prod  = wt_col * col_cnt;
        sum     = SW'(bias)
                + $signed({{(SW-WW-PW){1'b0}}, p_prod})
                - $signed({{(SW-WW-CW){1'b0}}, r_prod})
                - $signed({{(SW-WW-CW){1'b0}}, c_prod});
        nxt_b   = req_b & ((sum > 0) | (on_b & (sum == 0)));
    end
endmodule

// File: rtl/xbar_legalize.sv
// Turns a possibly conflicting neuron state into a legal, maximal matching:
// row resolution, then column resolution (highest priority, lowest index),
// then a row-major fill of requests whose input and output are both free.
// Purely combinational.
module xbar_legalize #(
    parameter int N  = 4,
    parameter int PW = 2,
    localparam int NN = N * N
) (
    input  logic [NN-1:0]    on_v,
    input  logic [NN-1:0]    req_v,
    input  logic [NN*PW-1:0] prio_v,
    output logic [NN-1:0]    grant_v
);
    logic [NN-1:0] row_keep, col_keep;

    // Keep one neuron per row: highest priority, lowest output index on tie.
    function automatic logic [NN-1:0] row_pass(input logic [NN-1:0] v,
                                               input logic [NN*PW-1:0] p);
        logic [NN-1:0] r;
        logic          found;
        logic [PW-1:0] bp;
        int            bj;
        r = '0;
        for (int i = 0; i < N; i++) begin
            found = 1'b0;
            bp    = '0;
            bj    = 0;
            for (int j = 0; j < N; j++) begin
                if (v[i*N+j] && (!found || p[(i*N+j)*PW +: PW] > bp)) begin
                    found = 1'b1;
                    bp    = p[(i*N+j)*PW +: PW];
                    bj    = j;
                end
            end
            if (found) r[i*N+bj] = 1'b1;
        end
        return r;
    endfunction

    // Keep one neuron per column: highest priority, lowest input index on tie.
    function automatic logic [NN-1:0] col_pass(input logic [NN-1:0] v,
                                               input logic [NN*PW-1:0] p);
        logic [NN-1:0] r;
        logic          found;
        logic [PW-1:0] bp;
        int            bi;
        r = '0;
        for (int j = 0; j < N; j++) begin
            found = 1'b0;
            bp    = '0;
            bi    = 0;
            for (int i = 0; i < N; i++) begin
                if (v[i*N+j] && (!found || p[(i*N+j)*PW +: PW] > bp)) begin
                    found = 1'b1;
                    bp    = p[(i*N+j)*PW +: PW];
                    bi    = i;
                end
            end
            if (found) r[bi*N+j] = 1'b1;
        end
        return r;
    endfunction

    // Add every request with a free input and output, in ascending bit order.
    function automatic logic [NN-1:0] fill_pass(input logic [NN-1:0] v,
                                                input logic [NN-1:0] rq);
        logic [NN-1:0] r;
        logic [N-1:0]  ru, cu;
        r  = v;
        ru = '0;
        cu = '0;
        for (int k = 0; k < NN; k++) begin
            if (v[k]) begin
                ru[k / N] = 1'b1;
                cu[k % N] = 1'b1;
            end
        end
        for (int k = 0; k < NN; k++) begin
            if (rq[k] && !ru[k / N] && !cu[k % N]) begin
                r[k]      = 1'b1;
                ru[k / N] = 1'b1;
                cu[k % N] = 1'b1;
            end
        end
        return r;
    endfunction

    // Chain the three passes.
    always_comb begin
        row_keep = row_pass(on_v, prio_v);
        col_keep = col_pass(row_keep, prio_v);
        grant_v  = fill_pass(col_keep, req_v);
    end
endmodule

// File: rtl/xbar_neuro_sched.sv
// Neural crossbar scheduler top: latches a request set on start, iterates the
// neuron grid one synchronous step per clock until stable or MAX_IT steps,
// then legalizes the result and strobes done for one cycle.
// Assumes start is only meaningful while idle; it is ignored otherwise.
module xbar_neuro_sched
    import xbar_sched_pkg::*;
#(
    parameter int N      = 4,
    parameter int PW     = 2,
    parameter int WW     = 6,
    parameter int MAX_IT = 2 * N,
    localparam int NN    = N * N,
    localparam int ITW   = $clog2(MAX_IT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NN-1:0]        req,
    input  logic [NN*PW-1:0]     prio,
    input  logic [WW-1:0]        wt_row,
    input  logic [WW-1:0]        wt_col,
    input  logic [WW-1:0]        wt_prio,
    input  logic signed [WW-1:0] bias,
    output logic                 busy,
    output logic                 done,
    output logic [NN-1:0]        grant,
    output logic [ITW-1:0]       iters
);
    phase_t                phase_q;
    logic [NN-1:0]         state_q, req_q, nxt_v, legal_v, grant_q;
    logic [NN*PW-1:0]      prio_q;
    logic [WW-1:0]         wr_q, wc_q, wp_q;
    logic signed [WW-1:0]  bias_q;
    logic [ITW-1:0]        it_q, iters_q;
    logic                  done_q;
    logic                  settled, at_limit;

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            logic [N-1:0] cv;
            // Gather this neuron's column from the row-major state vector.
            always_comb begin
                for (int r = 0; r < N; r++) cv[r] = state_q[r*N+gj];
            end
            xbar_cell #(.N(N), .PW(PW), .WW(WW)) u_cell (
                .req_b  (req_q[gi*N+gj]),
                .on_b   (state_q[gi*N+gj]),
                .row_v  (state_q[gi*N +: N]),
                .col_v  (cv),
                .prio_b (prio_q[(gi*N+gj)*PW +: PW]),
                .wt_row (wr_q),
                .wt_col (wc_q),
                .wt_prio(wp_q),
                .bias   (bias_q),
                .nxt_b  (nxt_v[gi*N+gj])
            );
        end
    end

    xbar_legalize #(.N(N), .PW(PW)) u_legal (
        .on_v   (nxt_v),
        .req_v  (req_q),
        .prio_v (prio_q),
        .grant_v(legal_v)
    );

    // Termination conditions for the current iteration.
    always_comb begin
        settled  = (nxt_v == state_q);
        at_limit = (it_q == ITW'(MAX_IT - 1));
    end

    // Phase control, iteration stepping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            state_q <= '0;
            req_q   <= '0;
            prio_q  <= '0;
            wr_q    <= '0;
            wc_q    <= '0;
            wp_q    <= '0;
            bias_q  <= '0;
            it_q    <= '0;
            iters_q <= '0;
            grant_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start) begin
                    req_q   <= req;
                    prio_q  <= prio;
                    wr_q    <= wt_row;
                    wc_q    <= wt_col;
                    wp_q    <= wt_prio;
                    bias_q  <= bias;
                    state_q <= req;
                    it_q    <= '0;
                    phase_q <= PH_RUN;
                end
            end else begin
                state_q <= nxt_v;
                it_q    <= it_q + 1'b1;
                if (settled || at_limit) begin
                    grant_q <= legal_v;
                    iters_q <= it_q + 1'b1;
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
            end
        end
    end

    // Drive outputs from registers.
    always_comb begin
        busy  = (phase_q == PH_RUN);
        done  = done_q;
        grant = grant_q;
        iters = iters_q;
    end
endmodule

// File: rtl/xbar_neuro_sched_chk.sv
// Property checker for xbar_neuro_sched, attached by bind. Keeps its own copy
// of the request matrix accepted at start and checks the result against it.
module xbar_neuro_sched_chk #(
    parameter int N      = 4,
    parameter int MAX_IT = 2 * N,
    localparam int NN    = N * N,
    localparam int ITW   = $clog2(MAX_IT + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [NN-1:0]  req,
    input logic           busy,
    input logic           done,
    input logic [NN-1:0]  grant,
    input logic [ITW-1:0] iters
);
    logic [NN-1:0] req_cap;

    // Remember the request set of the run that was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) req_cap <= '0;
        else if (start && !busy) req_cap <= req;
    end

    function automatic logic is_legal(input logic [NN-1:0] g);
        logic ok;
        int   rc, cc;
        ok = 1'b1;
        for (int a = 0; a < N; a++) begin
            rc = 0;
            cc = 0;
            for (int b = 0; b < N; b++) begin
                rc += int'(g[a*N+b]);
                cc += int'(g[b*N+a]);
            end
            if (rc > 1 || cc > 1) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic is_maximal(input logic [NN-1:0] g,
                                        input logic [NN-1:0] rq);
        logic         ok;
        logic [N-1:0] ru, cu;
        ok = 1'b1;
        ru = '0;
        cu = '0;
        for (int k = 0; k < NN; k++) begin
            if (g[k]) begin
                ru[k / N] = 1'b1;
                cu[k % N] = 1'b1;
            end
        end
        for (int k = 0; k < NN; k++) begin
            if (rq[k] && !ru[k / N] && !cu[k % N]) ok = 1'b0;
        end
        return ok;
    endfunction

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    a_r6_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> is_legal(grant));
    a_r6_subset: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((grant & ~req_cap) == '0));
    a_r8_maximal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> is_maximal(grant, req_cap));
    a_r4_iters_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iters >= ITW'(1) && iters <= ITW'(MAX_IT)));
    a_r5_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(!done)) |-> $stable(grant));
endmodule

bind xbar_neuro_sched xbar_neuro_sched_chk #(.N(N), .MAX_IT(MAX_IT)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .req  (req),
    .busy (busy),
    .done (done),
    .grant(grant),
    .iters(iters)
);

// File: tb/xbar_neuro_sched_bench.sv
module xbar_neuro_sched_bench;
    localparam int N = 4;
    localparam int PW = 2;
    localparam int WW = 6;
    localparam int MAX_IT = 8;
    localparam int NV = 10;
    // Entry: {req[15:0], prio[31:0], expected grant[15:0], expected iters[7:0]}
    localparam logic [71:0] VEC [NV] = '{
        {16'h8421, 32'h0000_0000, 16'h8421, 8'd1},  // R3 diagonal, no conflict
        {16'h20A0, 32'h0000_0000, 16'h2080, 8'd2},  // R10 example
        {16'h0003, 32'h0000_0004, 16'h0002, 8'd1},  // R7 row, priority wins
        {16'h0900, 32'h0000_0000, 16'h0100, 8'd1},  // R7 row tie, low index
        {16'h4004, 32'h0000_0000, 16'h0004, 8'd1},  // R7 column tie
        {16'h0000, 32'h0000_0000, 16'h0000, 8'd1},  // R4 empty settles at once
        {16'hFFFF, 32'h0000_0000, 16'h8421, 8'd8},  // R4 limit, R8 fill
        {16'h0013, 32'h0000_0000, 16'h0012, 8'd2},  // R3 L-shape
        {16'h4004, 32'h2000_0000, 16'h4000, 8'd1},  // R7 column priority
        {16'h0023, 32'h0000_0C00, 16'h0021, 8'd2}   // R3 priority bias
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] req = '0;
    logic [31:0] prio = '0;
    logic [WW-1:0] wt_row = 6'd2, wt_col = 6'd2, wt_prio = 6'd1;
    logic signed [WW-1:0] bias = 6'sd2;
    logic busy, done;
    logic [15:0] grant;
    logic [3:0] iters;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xbar_neuro_sched #(.N(N), .PW(PW), .WW(WW), .MAX_IT(MAX_IT)) u_xbar_neuro_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .prio(prio),
        .wt_row(wt_row), .wt_col(wt_col), .wt_prio(wt_prio), .bias(bias),
        .busy(busy), .done(done), .grant(grant), .iters(iters));

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] r, input logic [31:0] p, output int cyc);
        @(negedge clk);
        req = r; prio = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic bit legal16(input logic [15:0] g);
        for (int a = 0; a < 4; a++) begin
            if ($countones(g[a*4 +: 4]) > 1) return 1'b0;
            if ($countones({g[12+a], g[8+a], g[4+a], g[a]}) > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit maximal16(input logic [15:0] g, input logic [15:0] r);
        for (int k = 0; k < 16; k++) begin
            if (r[k] && $countones(g[(k/4)*4 +: 4]) == 0 &&
                $countones({g[12+k%4], g[8+k%4], g[4+k%4], g[k%4]}) == 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int best16(input logic [15:0] r);
        int best = 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++) begin
                        if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                            int s = int'(r[a]) + int'(r[4+b]) + int'(r[8+c]) + int'(r[12+d]);
                            if (s > best) best = s;
                        end
                    end
        return best;
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] g_prev;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {busy, done}, 0);
        chk(grant == 16'h0 && iters == 4'd0, "R1 reset grant/iters", {grant, iters}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            run(VEC[n][71:56], VEC[n][55:24], cyc);
            chk(cyc == int'(VEC[n][7:0]), $sformatf("R4 case %0d done latency", n), cyc, VEC[n][7:0]);
            chk(iters == VEC[n][3:0], $sformatf("R4 case %0d iters", n), iters, VEC[n][3:0]);
            chk(grant == VEC[n][23:8], $sformatf("R3 R7 R10 case %0d grant", n), grant, VEC[n][23:8]);
            chk(!busy, $sformatf("R5 case %0d busy low at done", n), busy, 0);
            g_prev = grant;
            @(negedge clk);
            chk(!done && grant == g_prev, $sformatf("R5 case %0d pulse/hold", n), {done, grant}, {1'b0, g_prev});
        end

        // R2: busy rises one cycle after start is sampled.
        @(negedge clk);
        req = 16'hFFFF; prio = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        // R9: a start mid-run with a different request is ignored.
        @(negedge clk);
        @(negedge clk);
        req = 16'h0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(grant == 16'h8421 && iters == 4'd8, "R9 mid-run start ignored", {grant, iters}, {16'h8421, 4'd8});
        @(negedge clk);
        chk(!busy && !done, "R9 no relaunch after ignored start", {busy, done}, 0);
        @(negedge clk);
        chk(!busy && !done && grant == 16'h8421, "R9 state unchanged", {busy, done, grant}, 16'h8421);

        // R6 R8: random requests, legality, maximality and half-optimum bound.
        for (int t = 0; t < 30; t++) begin
            logic [15:0] r;
            r = 16'($urandom);
            run(r, $urandom, cyc);
            chk(legal16(grant), "R6 random legal", grant, r);
            chk((grant & ~r) == 16'h0, "R6 random subset", grant, r);
            chk(maximal16(grant, r), "R8 random maximal", grant, r);
            chk(2 * $countones(grant) >= best16(r), "R8 half of maximum", $countones(grant), best16(r));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule